// File: doc/BRIEF.md
# Supply-Fail Deselect and Sleep Sequencer

This block supervises the main supply of a battery-backed memory and clock device. It takes two comparator flags that have already been synchronised to the system clock. One flag says the supply is under the power-fail threshold. The other says it is under the battery-switchover threshold. From these flags the block drives the signals that protect the device. It deselects the serial interface, holds the system in reset, selects the battery, and puts the outputs into high impedance. When either flag first asserts, it also sends a one-cycle pulse that aborts any transfer in progress and clears the address pointer.

After the supply comes back, protection and reset are held for a parameterised number of clocks, `TREC_CYCLES`. If the supply fails again during that count, the whole sequence starts over.

The block also holds the sleep request bit. Software can write this bit only while the device runs on the main supply, and writing it only arms the feature. The general-purpose RAM is cut off from the battery at the next entry into battery operation. The clock registers are not part of that RAM and stay powered. The bit survives power cycles and is cleared only when software writes 0. A sticky flag records that the RAM has been isolated and that its contents are therefore lost.

Top module: `pfd_seq_top`

## Requirements
- R1: When the block leaves normal operation because either flag asserts, `abort_o` is high for exactly the one cycle after the flag is sampled, and it is never high on any other transition.
- R2: `deselect_o` and `sys_rst_o` are high in the cycle after either flag is sampled high, and they stay high in every state except normal operation.
- R3: Once both flags are sampled low after a failure, `deselect_o` and `sys_rst_o` stay high for exactly `TREC_CYCLES` more cycles, so they are first low `TREC_CYCLES+1` cycles after the flags clear.
- R4: If the power-fail flag asserts at any point during the recovery count, the block goes back to the deselected state without an abort pulse. The full `TREC_CYCLES` interval then starts again once the flag clears.
- R5: While the switchover flag is sampled high, `bat_sel_o` and `out_hiz_o` are high in the next cycle. When the switchover flag is sampled low, both are low in the next cycle. Recovery begins only if the power-fail flag is also low; otherwise the block stays deselected.
- R6: A write to the sleep bit (`slp_wr_i` with value `slp_wdata_i`) takes effect only in normal operation, and the value is read back on `slp_arm_o` in the next cycle. A write made in any other state leaves `slp_arm_o` unchanged.
- R7: An armed sleep bit does not isolate anything while the main supply is in use. `ram_iso_o` rises together with `bat_sel_o` when battery operation is entered with the bit set, and falls together with `bat_sel_o`.
- R8: The sleep bit is kept through a whole fail, battery and recover cycle. It clears only when software writes 0, after which entering battery operation no longer raises `ram_iso_o`.
- R9: `ram_data_lost_o` goes high together with the first `ram_iso_o` and stays high until `rst_ni` is asserted.
- R10: While `rst_ni` is low, the block is in normal operation and every output is low, including the sleep bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pf_flag_i | input | 1 | Supply below power-fail threshold (synchronised) |
| so_flag_i | input | 1 | Supply below battery-switchover threshold (synchronised) |
| slp_wr_i | input | 1 | Write strobe for the sleep bit |
| slp_wdata_i | input | 1 | Value to write to the sleep bit |
| deselect_o | output | 1 | Interface deselected, writes blocked |
| sys_rst_o | output | 1 | Reset output to the host, active high |
| bat_sel_o | output | 1 | Battery selected as the supply |
| out_hiz_o | output | 1 | All device outputs in high impedance |
| abort_o | output | 1 | One-cycle pulse that aborts the transfer and clears the pointer |
| ram_iso_o | output | 1 | General-purpose RAM cut off from the battery |
| slp_arm_o | output | 1 | Read-back of the sleep bit |
| ram_data_lost_o | output | 1 | Sticky flag: RAM has been isolated |

## Verification
The bench releases the power-fail flag and lets it reassert after every possible number of recovery cycles, from 1 to `TREC_CYCLES`. After each restart it checks that the full interval runs again. A counter that does not restart would end reset early, and an off-by-one count would move the release by one cycle; both show up in the cycle-exact check.

The bench also writes the sleep bit while the block is deselected, and it visits battery operation with the bit set and with it cleared. A latch that isolates the RAM at once, that accepts writes during a failure, or that clears itself on power-up would show a wrong `ram_iso_o` or `slp_arm_o`.

Finally, the bench drops straight from normal operation into battery operation. This checks that the abort pulse fires on that path too, and that it does not fire when recovery is interrupted.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_DESEL  = 2'd1,
    ST_ONBAT  = 2'd2,
    ST_RECOV  = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pfd_timer.sv
module pfd_timer #(
  parameter int TREC_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(TREC_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TREC_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R3
  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0); // R4
endmodule

// File: rtl/pfd_fsm.sv
module pfd_fsm
  import pfd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pf_i,
  input  logic       so_i,
  input  logic       rec_done_i,
  output pwr_state_e state_o,
  output logic       bat_enter_o,
  output logic       bat_leave_o,
  output logic       abort_o
);
  pwr_state_e state_q, state_d;
  logic abort_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL: if (so_i) state_d = ST_ONBAT;
                 else if (pf_i) state_d = ST_DESEL;
      ST_DESEL:  if (so_i) state_d = ST_ONBAT;
                 else if (!pf_i) state_d = ST_RECOV;
      ST_ONBAT:  if (!so_i) state_d = pf_i ? ST_DESEL : ST_RECOV;
      ST_RECOV:  if (so_i) state_d = ST_ONBAT;
                 else if (pf_i) state_d = ST_DESEL;
                 else if (rec_done_i) state_d = ST_NORMAL;
      default:   state_d = ST_DESEL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_NORMAL;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= (state_q == ST_NORMAL) && (state_d != ST_NORMAL);
    end
  end

  assign state_o     = state_q;
  assign abort_o     = abort_q;
  assign bat_enter_o = (state_q != ST_ONBAT) && (state_d == ST_ONBAT);
  assign bat_leave_o = (state_q == ST_ONBAT) && (state_d != ST_ONBAT);

  AST_PF_LEAVES_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_i || so_i) |=> state_q != ST_NORMAL); // R2
  AST_ABORT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |=> !abort_q); // R1
  AST_RECOV_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOV && !pf_i && !so_i && !rec_done_i) |=> state_q == ST_RECOV); // R3
endmodule

// File: rtl/pfd_sleep.sv
module pfd_sleep (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wdata_i,
  input  logic bat_enter_i,
  input  logic bat_leave_i,
  input  logic bat_sel_i,
  output logic armed_o,
  output logic iso_o,
  output logic lost_o
);
  logic armed_q, iso_q, lost_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      iso_q   <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      if (wr_en_i) armed_q <= wdata_i;
      if (bat_enter_i && armed_q) begin
        iso_q  <= 1'b1;
        lost_q <= 1'b1;
      end else if (bat_leave_i) begin
        iso_q  <= 1'b0;
      end
    end
  end

  assign armed_o = armed_q;
  assign iso_o   = iso_q;
  assign lost_o  = lost_q;

  AST_ISO_ON_BAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iso_q |-> bat_sel_i); // R7
  AST_LOST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_q |=> lost_q); // R9
  AST_ARM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(armed_q)); // R8
endmodule

// File: rtl/pfd_seq_top.sv
module pfd_seq_top
  import pfd_pkg::*;
#(
  parameter int TREC_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pf_flag_i,
  input  logic so_flag_i,
  input  logic slp_wr_i,
  input  logic slp_wdata_i,
  output logic deselect_o,
  output logic sys_rst_o,
  output logic bat_sel_o,
  output logic out_hiz_o,
  output logic abort_o,
  output logic ram_iso_o,
  output logic slp_arm_o,
  output logic ram_data_lost_o
);
  pwr_state_e state;
  logic rec_done, bat_enter, bat_leave, normal;

  pfd_timer #(.TREC_CYCLES(TREC_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state == ST_RECOV),
    .done_o (rec_done)
  );

  pfd_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pf_i        (pf_flag_i),
    .so_i        (so_flag_i),
    .rec_done_i  (rec_done),
    .state_o     (state),
    .bat_enter_o (bat_enter),
    .bat_leave_o (bat_leave),
    .abort_o     (abort_o)
  );

  assign normal     = (state == ST_NORMAL);
  assign deselect_o = !normal;
  assign sys_rst_o  = !normal;
  assign bat_sel_o  = (state == ST_ONBAT);
  assign out_hiz_o  = bat_sel_o;

  pfd_sleep u_sleep (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (slp_wr_i && normal),
    .wdata_i     (slp_wdata_i),
    .bat_enter_i (bat_enter),
    .bat_leave_i (bat_leave),
    .bat_sel_i   (bat_sel_o),
    .armed_o     (slp_arm_o),
    .iso_o       (ram_iso_o),
    .lost_o      (ram_data_lost_o)
  );

  AST_SO_TO_BAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_flag_i |=> bat_sel_o); // R5
  AST_NO_SO_MAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !so_flag_i |=> !bat_sel_o); // R5
  AST_PF_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_flag_i |=> deselect_o && sys_rst_o); // R2
  AST_WR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slp_wr_i && deselect_o) |=> $stable(slp_arm_o)); // R6
endmodule

// File: tb/pfd_seq_top_tb_top.sv
module pfd_seq_top_tb_top;
  localparam int TREC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pf = 1'b0, so = 1'b0, wr = 1'b0, wd = 1'b0;
  logic desel, srst, bsel, hiz, abrt, iso, arm, lost;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  pfd_seq_top #(.TREC_CYCLES(TREC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pf_flag_i(pf), .so_flag_i(so),
    .slp_wr_i(wr), .slp_wdata_i(wd), .deselect_o(desel), .sys_rst_o(srst),
    .bat_sel_o(bsel), .out_hiz_o(hiz), .abort_o(abrt), .ram_iso_o(iso),
    .slp_arm_o(arm), .ram_data_lost_o(lost)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // Release pf (so already low); reset holds TREC cycles, drops on TREC+1
  task automatic recover_check(input string req);
    pf = 1'b0;
    for (int k = 1; k <= TREC + 1; k++) begin
      tick(1);
      chk(req, desel, k <= TREC);
      chk(req, srst, k <= TREC);
    end
  endtask

  task automatic write_slp(input logic v);
    wr = 1'b1; wd = v;
    tick(1);
    wr = 1'b0;
  endtask

  initial begin
    tick(2);
    // R10 reset state
    chk("R10", desel, 1'b0); chk("R10", srst, 1'b0); chk("R10", bsel, 1'b0);
    chk("R10", abrt, 1'b0); chk("R10", iso, 1'b0); chk("R10", arm, 1'b0);
    chk("R10", lost, 1'b0); chk("R10", hiz, 1'b0);
    rst_n = 1'b1;
    tick(2);

    // R1 R2 power-fail entry
    pf = 1'b1;
    tick(1);
    chk("R1", abrt, 1'b1); chk("R2", desel, 1'b1); chk("R2", srst, 1'b1);
    chk("R5", bsel, 1'b0);
    tick(1);
    chk("R1", abrt, 1'b0); chk("R2", desel, 1'b1);
    tick(3);
    chk("R2", srst, 1'b1);
    recover_check("R3");
    chk("R1", abrt, 1'b0);

    // R4 restart at every point of the recovery count
    for (int j = 1; j <= TREC; j++) begin
      pf = 1'b1; tick(2);
      pf = 1'b0; tick(j);
      chk("R4", desel, 1'b1);
      pf = 1'b1; tick(1);
      chk("R4", desel, 1'b1); chk("R4", abrt, 1'b0);
      tick(1);
      recover_check("R4");
    end

    // R5 direct drop to battery, then back with pf still high
    so = 1'b1; pf = 1'b1;
    tick(1);
    chk("R5", bsel, 1'b1); chk("R5", hiz, 1'b1); chk("R1", abrt, 1'b1);
    chk("R7", iso, 1'b0);
    tick(1);
    chk("R1", abrt, 1'b0);
    so = 1'b0;
    tick(1);
    chk("R5", bsel, 1'b0); chk("R5", hiz, 1'b0); chk("R5", desel, 1'b1);
    tick(TREC + 2);
    chk("R5", desel, 1'b1);
    recover_check("R5");

    // R6 R7 arm, then no isolation on main supply
    write_slp(1'b1);
    chk("R6", arm, 1'b1); chk("R7", iso, 1'b0);
    tick(5);
    chk("R7", iso, 1'b0); chk("R9", lost, 1'b0);
    pf = 1'b1; tick(2);
    chk("R7", iso, 1'b0);
    write_slp(1'b0); // ignored while deselected
    chk("R6", arm, 1'b1);
    so = 1'b1; tick(1);
    chk("R7", iso, 1'b1); chk("R7", bsel, 1'b1); chk("R9", lost, 1'b1);
    tick(4);
    chk("R7", iso, 1'b1);
    so = 1'b0; tick(1);
    chk("R7", iso, 1'b0); chk("R7", bsel, 1'b0);
    recover_check("R3");
    chk("R8", arm, 1'b1); chk("R9", lost, 1'b1);

    // R8 clear by write 0, next battery visit does not isolate
    write_slp(1'b0);
    chk("R8", arm, 1'b0);
    so = 1'b1; pf = 1'b1; tick(2);
    chk("R8", iso, 1'b0); chk("R8", bsel, 1'b1); chk("R9", lost, 1'b1);
    so = 1'b0; tick(1);
    recover_check("R3");
    chk("R9", lost, 1'b1);

    // R6 write while recovering ignored
    pf = 1'b1; tick(2); pf = 1'b0; tick(2);
    write_slp(1'b1);
    chk("R6", arm, 1'b0);
    tick(TREC + 2);
    chk("R6", desel, 1'b0);

    // R10 reset clears sticky state
    write_slp(1'b1);
    rst_n = 1'b0; tick(1);
    chk("R10", arm, 1'b0); chk("R10", lost, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule